// File: doc/BRIEF.md
# Cascaded DMA Request Arbiter

This block decides which of eight DMA channels may own the transfer engine. The channels form two four-slot controllers. The lower controller arbitrates channels 0 to 3. The upper controller arbitrates four slots: slot 0 is channel 4 and slots 1 to 3 are channels 5 to 7. Channel 4 has no request pin of its own. It is requested whenever any of channels 0 to 3 is active, and while the upper controller holds it, the lower controller may grant one of its own channels. The result is a two-level tree in which the lower group competes as a single entrant of the upper group.

Request inputs may change at any time. Each one is first brought to the active-high form selected by a configuration input, then passed through a multi-stage synchronizer. The winner is chosen by a fixed order or a rotating order, selected per cycle by a configuration input. A grant stays with its channel until that channel's synchronized request goes inactive. The acknowledge pins show the grant at a second programmable level. The reset input is asynchronous and active low. Internally it is released in step with the clock, two edges after the pin rises.

Top module: `dma_cascade_arbiter`

## Requirements
- R1: While reset is held, every acknowledge pin is at its inactive level. The inactive level is 0 when cfg_ack_high=1 and 1 when cfg_ack_high=0.
- R2: With cfg_req_high=1 a request pin at 1 is a request. With cfg_req_high=0 a request pin at 0 is a request.
- R3: An acknowledge pin shows the channel's grant state directly when cfg_ack_high=1, and inverted when cfg_ack_high=0.
- R4: On an idle arbiter, a lone request applied before clock edge k is acknowledged after edge k+2, and not before.
- R5: At most one of the seven channels is granted at any time.
- R6: When cfg_rotate=0, the lowest requesting slot wins within each controller. Any request on channels 0 to 3 therefore beats channels 5 to 7.
- R7: When cfg_rotate=1, the search within a controller starts at the slot after the one granted most recently. After reset the most recent slot is taken to be slot 3. The most recent slot is updated on every grant, in both modes.
- R8: A grant is not moved while the granted request stays active, even if higher-priority requests arrive.
- R9: After the granted request goes inactive, the acknowledge drops after the third clock edge. A pending request is granted one edge later.
- R10: Channel 4 stays granted in the upper controller while any of channels 0 to 3 requests. A lower-group channel is acknowledged only while channel 4 is held. Channels 5 to 7 are served once no lower-group request remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req_high | input | 1 | 1: requests active high; 0: active low |
| cfg_ack_high | input | 1 | 1: acknowledges active high; 0: active low |
| cfg_rotate | input | 1 | 1: rotating priority; 0: fixed priority |
| chan_req_a | input | 4 | Requests of channels 0 to 3 (bit n = channel n) |
| chan_req_b | input | 3 | Requests of channels 5 to 7 (bit 0 = channel 5) |
| chan_ack_a | output | 4 | Acknowledges of channels 0 to 3 |
| chan_ack_b | output | 3 | Acknowledges of channels 5 to 7 |

## Verification
The following are checked on every cycle by assertions:
- at most one grant exists at a time;
- a lower-group grant never exists without channel 4 held above it;
- a held grant does not move while its request stays active;
- a grant whose request has fallen is gone on the next edge;
- a fixed-mode grant never skips a lower requesting slot;
- the acknowledges are quiet during reset.

Some properties depend on the history of requests and on the pin levels, and only the bench scenarios can show them:
- the three-edge latency through the synchronizer;
- the rotation order after earlier grants;
- the two polarity settings;
- the one-cycle gap when a grant is handed over.

A behavioural model in the bench compares every acknowledge pin on every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int unsigned CH_PER_CTRL = 4;
  localparam int unsigned CH_IW       = $clog2(CH_PER_CTRL);
  localparam int unsigned EXT_CH      = 2 * CH_PER_CTRL - 1;

  typedef logic [CH_IW-1:0] ch_idx_t;

  function automatic logic [CH_PER_CTRL-1:0] idx_to_onehot(ch_idx_t i);
    logic [CH_PER_CTRL-1:0] v;
    v    = '0;
    v[i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int unsigned W      = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_rest
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rotate,
  input  logic                   allow,
  input  logic [CH_PER_CTRL-1:0] req,
  output logic [CH_PER_CTRL-1:0] grant,
  output logic                   start,
  output ch_idx_t                start_idx
);
  logic    busy_q, busy_d;
  ch_idx_t idx_q, idx_d;
  ch_idx_t last_q, last_d;
  ch_idx_t base, cand, pick_idx;
  logic    found;

  // Search order begins at base and wraps around the slots.
  always_comb begin
    base     = rotate ? ch_idx_t'(last_q + 1'b1) : '0;
    found    = 1'b0;
    pick_idx = base;
    cand     = base;
    for (int k = 0; k < CH_PER_CTRL; k++) begin
      cand = ch_idx_t'(base + ch_idx_t'(k));
      if (!found && req[cand]) begin
        found    = 1'b1;
        pick_idx = cand;
      end
    end
  end

  assign start     = !busy_q && allow && found;
  assign start_idx = pick_idx;

  // Next state: hold while the request stays, release when it falls.
  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    last_d = last_q;
    if (busy_q) begin
      if (!req[idx_q]) busy_d = 1'b0;
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = pick_idx;
      last_d = pick_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= ch_idx_t'(CH_PER_CTRL - 1);
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign grant = busy_q ? idx_to_onehot(idx_q) : '0;

  // R8: an active granted request keeps its grant
  a_r8_hold_grant: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & req) != '0) |=> (grant == $past(grant)));

  // R9: a granted request that has fallen loses the grant
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant != '0) && ((grant & req) == '0)) |=> (grant == '0));

  // R6: in fixed mode a fresh grant never skips a lower requesting slot
  a_r6_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rotate) |=> ((($past(req)) & (grant - 1'b1)) == '0));
endmodule

// File: rtl/dma_cascade_arbiter.sv
module dma_cascade_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_req_high,
  input  logic                   cfg_ack_high,
  input  logic                   cfg_rotate,
  input  logic [CH_PER_CTRL-1:0] chan_req_a,
  input  logic [CH_PER_CTRL-2:0] chan_req_b,
  output logic [CH_PER_CTRL-1:0] chan_ack_a,
  output logic [CH_PER_CTRL-2:0] chan_ack_b
);
  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe_q, rst_pipe_d;
  logic       rst_int_n;

  assign rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign rst_int_n = rst_pipe_q[1];

  // Normalise the request level, then synchronise.
  logic [EXT_CH-1:0] req_raw, req_norm, req_act;

  assign req_raw  = {chan_req_b, chan_req_a};
  assign req_norm = cfg_req_high ? req_raw : ~req_raw;

  dma_req_sync #(.W(EXT_CH), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (req_norm),
    .q     (req_act)
  );

  // Two-level tree: the lower group enters the upper one as slot 0.
  logic [CH_PER_CTRL-1:0] lo_req, up_req, lo_grant, up_grant;
  logic                   up_start, lo_start, lo_allow;
  ch_idx_t                up_start_idx, lo_start_idx;

  assign lo_req = req_act[CH_PER_CTRL-1:0];
  assign up_req = {req_act[EXT_CH-1:CH_PER_CTRL], |lo_req};

  dma_prio_arb i_upper (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rotate    (cfg_rotate),
    .allow     (1'b1),
    .req       (up_req),
    .grant     (up_grant),
    .start     (up_start),
    .start_idx (up_start_idx)
  );

  assign lo_allow = up_grant[0] || (up_start && (up_start_idx == '0));

  dma_prio_arb i_lower (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rotate    (cfg_rotate),
    .allow     (lo_allow),
    .req       (lo_req),
    .grant     (lo_grant),
    .start     (lo_start),
    .start_idx (lo_start_idx)
  );

  // Acknowledge level.
  assign chan_ack_a = cfg_ack_high ? lo_grant : ~lo_grant;
  assign chan_ack_b = cfg_ack_high ? up_grant[CH_PER_CTRL-1:1] : ~up_grant[CH_PER_CTRL-1:1];

  // R5: one grant across both controllers
  a_r5_single_grant: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({up_grant[CH_PER_CTRL-1:1], lo_grant}));

  // R10: a lower-group grant sits under a held channel 4
  a_r10_cascade_link: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lo_grant != '0) |-> up_grant[0]);

  // R10: the lower controller only starts a grant when the upper one lets it
  a_r10_lower_gated: assert property (@(posedge clk) disable iff (!rst_int_n)
    lo_start |-> lo_allow);

  // R1: no grant while reset is held internally
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (({up_grant, lo_grant} == '0) && (lo_start_idx == lo_start_idx)));
endmodule

// File: tb/test_dma_cascade_arbiter.sv
`timescale 1ns/1ps
module test_dma_cascade_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_req_high, cfg_ack_high, cfg_rotate;
  logic [3:0] ma;          // logical requests, channels 0..3
  logic [2:0] mb;          // logical requests, channels 5..7
  logic [3:0] chan_req_a, chan_ack_a;
  logic [2:0] chan_req_b, chan_ack_b;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign chan_req_a = cfg_req_high ? ma : ~ma;
  assign chan_req_b = cfg_req_high ? mb : ~mb;

  dma_cascade_arbiter i_dma_cascade_arbiter (
    .clk(clk), .rst_n(rst_n), .cfg_req_high(cfg_req_high), .cfg_ack_high(cfg_ack_high),
    .cfg_rotate(cfg_rotate), .chan_req_a(chan_req_a), .chan_req_b(chan_req_b),
    .chan_ack_a(chan_ack_a), .chan_ack_b(chan_ack_b));

  // Behavioural reference model.
  bit       rs1, rs2;
  bit [6:0] ms1, ms2;
  bit       mbusy, sbusy;
  int       midx, mlast, sidx, slast;

  function automatic int pick(bit [3:0] r, int last, bit rot);
    int base = rot ? (last + 1) % 4 : 0;
    for (int k = 0; k < 4; k++) if (r[(base + k) % 4]) return (base + k) % 4;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 = 0; rs2 = 0; ms1 = 0; ms2 = 0;
      mbusy = 0; midx = 0; mlast = 3; sbusy = 0; sidx = 0; slast = 3;
    end else begin
      if (!rs2) begin
        ms1 = 0; ms2 = 0; mbusy = 0; midx = 0; mlast = 3; sbusy = 0; sidx = 0; slast = 3;
      end else begin
        bit [3:0] lo, mr;
        bit old_g4, mstart, allow;
        lo = ms2[3:0];
        mr = {ms2[6:4], |lo};
        old_g4 = mbusy && midx == 0;
        mstart = 0;
        if (mbusy) begin
          if (!mr[midx]) mbusy = 0;
        end else if (mr != 0) begin
          midx = pick(mr, mlast, cfg_rotate); mlast = midx; mbusy = 1; mstart = 1;
        end
        allow = old_g4 || (mstart && midx == 0);
        if (sbusy) begin
          if (!lo[sidx]) sbusy = 0;
        end else if (allow && lo != 0) begin
          sidx = pick(lo, slast, cfg_rotate); slast = sidx; sbusy = 1;
        end
        ms2 = ms1;
        ms1 = {mb, ma};
      end
      rs2 = rs1;
      rs1 = 1;
    end
  end

  function automatic bit [6:0] model_grant();
    bit [6:0] g = '0;
    if (sbusy) g[sidx] = 1'b1;
    if (mbusy && midx != 0) g[3 + midx] = 1'b1;
    return g;
  endfunction

  function automatic bit [6:0] to_pins(bit [6:0] g);
    return cfg_ack_high ? g : ~g;
  endfunction

  task automatic chk(string tag, bit [6:0] exp_grant);
    bit [6:0] act, exp_p;
    act   = {chan_ack_b, chan_ack_a};
    exp_p = to_pins(exp_grant);
    checks++;
    if (act !== exp_p) begin
      errors++;
      $display("FAIL %s: acks=%b expected=%b at %0t", tag, act, exp_p, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !finished) chk("R5 R6 R7 R8 R9 R10 model", model_grant());
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(bit rh, bit ah, bit rot);
    rst_n = 0;
    ma = 0; mb = 0;
    cfg_req_high = rh; cfg_ack_high = ah; cfg_rotate = rot;
    wait_cyc(2);
    chk("R1 reset", 7'b0);
    rst_n = 1;
    wait_cyc(6);
    chk("R1 idle after reset", 7'b0);
  endtask

  initial begin
    rst_n = 0; ma = 0; mb = 0;
    cfg_req_high = 1; cfg_ack_high = 1; cfg_rotate = 0;
    @(negedge clk);

    // Fixed priority, active-high requests and acknowledges.
    do_reset(1, 1, 0);
    mb = 3'b010;               // channel 6
    wait_cyc(2); chk("R4 not yet", 7'b0);
    wait_cyc(1); chk("R4 granted after third edge", 7'b0100000);
    ma = 4'b0001;              // channel 0 arrives while 6 is held
    wait_cyc(4); chk("R8 hold", 7'b0100000);
    mb = 3'b000;
    wait_cyc(3); chk("R9 gap", 7'b0);
    wait_cyc(1); chk("R9 R10 next grant ch0", 7'b0000001);
    ma = 4'b0011; mb = 3'b001;
    wait_cyc(4); chk("R8 ch0 kept", 7'b0000001);
    ma = 4'b0010;              // drop channel 0, channel 1 and 5 pending
    wait_cyc(3); chk("R9 gap lower", 7'b0);
    wait_cyc(1); chk("R10 ch4 held, ch1 before ch5", 7'b0000010);
    ma = 4'b0000;
    wait_cyc(3); chk("R9 gap upper", 7'b0);
    wait_cyc(1); chk("R10 ch5 after lower group", 7'b0010000);
    mb = 3'b000; wait_cyc(5);
    ma = 4'b1100; mb = 3'b100;
    wait_cyc(3); chk("R6 ch2 wins", 7'b0000100);
    ma = 0; mb = 0; wait_cyc(5);
    mb = 3'b110;
    wait_cyc(3); chk("R6 ch6 before ch7", 7'b0100000);
    mb = 0; wait_cyc(5);

    // Rotating priority.
    do_reset(1, 1, 1);
    ma = 4'b0010;
    wait_cyc(3); chk("R7 ch1", 7'b0000010);
    ma = 0; wait_cyc(5);
    ma = 4'b0101;
    wait_cyc(3); chk("R7 ch2 after ch1", 7'b0000100);
    ma = 0; wait_cyc(5);
    mb = 3'b010;
    wait_cyc(3); chk("R7 ch6", 7'b0100000);
    mb = 0; wait_cyc(5);
    mb = 3'b101;
    wait_cyc(3); chk("R7 ch7 after ch6", 7'b1000000);
    mb = 0; wait_cyc(5);

    // Active-low requests and acknowledges.
    do_reset(0, 0, 0);
    ma = 4'b1000;
    wait_cyc(3); chk("R2 R3 ch3 low level", 7'b0001000);
    ma = 0; wait_cyc(5);
    chk("R3 idle all high", 7'b0);

    // Random traffic with both priority modes.
    for (int pass = 0; pass < 2; pass++) begin
      do_reset(1, 1, pass[0]);
      for (int c = 0; c < 3000; c++) begin
        if ($urandom_range(3) == 0) begin
          ma = 4'($urandom);
          mb = 3'($urandom);
        end
        @(negedge clk);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: acks=%b expected=done", {chan_ack_b, chan_ack_a});
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule